// File: doc/BRIEF.md
# Single-Precision Round and Pack Stage

This block is the last stage of a single-precision floating-point datapath. It takes a sign, an unbiased two's-complement exponent and a 27-bit extended significand, and returns a packed 32-bit IEEE single-precision word. The significand carries a leading hidden one, 23 fraction bits and three extra low bits for guard, round and sticky. Alongside the word come the inexact, underflow and overflow exception flags. The arithmetic unit in front of it must supply a normalized, nonzero significand. NaN operands and exact zeros are handled elsewhere.

The block applies one of four rounding modes. Values below the normal range are shifted into subnormal form, and a sticky bit keeps track of any bits shifted out. A value one step below the minimum exponent that rounds up into the normal range is not treated as tiny. An optional flush mode replaces every tiny value with zero or with the smallest subnormal, chosen by mode and sign. Overflow saturates to infinity or to the largest finite value, also chosen by mode and sign. One operand can be accepted every clock, and its result is registered one cycle later.

Top module: `rp_round_pack`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous clock and is 0 after reset. The word and the flags update only on cycles that have a valid input, and all outputs reset to 0.
- R2: The rounding mode input selects the behaviour: 0 is nearest-even, 1 is toward zero, 2 is toward +infinity, 3 is toward -infinity. An increment happens only when significand bits [2:0] are nonzero. Nearest adds 3 plus bit 3. Toward +infinity adds 8 for a positive sign only. Toward -infinity adds 8 for a negative sign only.
- R3: A rounding carry out of bit 26 shifts the significand right by one and raises the exponent by one.
- R4: `out_inexact` is 1 whenever the bits that are rounded away, after any denormalizing shift, are nonzero.
- R5: A normal result packs as {sign, exponent+127 in bits [30:23], fraction bits 25..3 of the rounded significand in bits [22:0]}. The input significand has bit 26 set.
- R6: With flush mode off, an exponent below -126 shifts the significand right by (-126 - exponent). Any bits lost are ORed into bit 0, and the value is then rounded. A result whose hidden bit is still clear packs with exponent field 0. If such a result is inexact, underflow is raised.
- R7: With flush mode off, an exponent of -127 whose rounding carries out of bit 26 gives the smallest normal magnitude (0x00800000 with the sign). It raises inexact and does not raise underflow.
- R8: With flush mode on and exponent below -126, underflow and inexact are raised. Nearest and toward-zero give a signed zero. Toward +infinity gives 0x00000001 when positive and 0x80000000 when negative. Toward -infinity gives 0x00000000 when positive and 0x80000001 when negative.
- R9: An exponent above 127 after rounding raises overflow and inexact. Nearest gives infinity (0x7F800000 with sign). Toward zero gives the largest finite value (0x7F7FFFFF with sign). Toward +infinity gives +infinity or -largest. Toward -infinity gives +largest or -infinity.
- R10: A subnormal result that is exact raises underflow only when `uf_trap_en` is 1.
- R11: Bit 31 of the output word always equals the input sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Sign of the operand |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_sig | input | 27 | Significand: hidden bit, 23 fraction bits, 3 extra low bits |
| rnd_mode | input | 2 | Rounding mode (0 nearest, 1 zero, 2 up, 3 down) |
| flush_en | input | 1 | Replace tiny values with zero or the smallest subnormal |
| uf_trap_en | input | 1 | Underflow trap enable; makes exact tiny results flag underflow |
| out_valid | output | 1 | Result present this cycle |
| out_word | output | 32 | Packed single-precision result |
| out_inexact | output | 1 | Inexact flag |
| out_underflow | output | 1 | Underflow flag |
| out_overflow | output | 1 | Overflow flag |

## Verification
The stage holds no state beyond its output register, so any wrong internal decision shows up in the word or flags one clock after the operand that caused it. A bad sticky shift or tie decision shows as a one-ulp error in the low fraction bits, or as a wrong inexact flag. A wrong tininess or flush choice shows as the wrong exponent field, or as an underflow flag at the boundary exponents -127 and -126. Overflow selection faults show as a swapped infinity and largest-finite pattern for one sign and mode pair. For that reason the stimulus is concentrated on those exponents, on all-ones significands and on every mode and sign combination.

// File: rtl/rp_pkg.sv
package rp_pkg;
   typedef enum logic [1:0] {
      RM_NEAREST = 2'd0,
      RM_ZERO    = 2'd1,
      RM_UP      = 2'd2,
      RM_DOWN    = 2'd3
   } rmode_e;
endpackage

// File: rtl/rp_round_inc.sv
// Rounding increment: decides what to add to an extended significand whose
// three lowest bits are the extra precision.
module rp_round_inc #(
   parameter int SIG_W = 27
) (
   input  logic             sign,
   input  logic [1:0]       mode,
   input  logic [SIG_W-1:0] sig,
   output logic [SIG_W:0]   sum,
   output logic             lost_nz
);
   import rp_pkg::*;

   logic [3:0] inc;

   assign lost_nz = |sig[2:0];

   always_comb begin
      inc = 4'd0;
      if (lost_nz) begin
         case (rmode_e'(mode))
            RM_NEAREST: inc = 4'd3 + {3'b000, sig[3]};
            RM_UP:      inc = sign ? 4'd0 : 4'd8;
            RM_DOWN:    inc = sign ? 4'd8 : 4'd0;
            default:    inc = 4'd0;
         endcase
      end
   end

   assign sum = {1'b0, sig} + (SIG_W+1)'(inc);

   // R2: no increment when nothing is lost
   always_comb begin
      if (!lost_nz) assert (sum[SIG_W-1:0] == sig) else $error("a_r2_exact_no_inc");
   end
endmodule

// File: rtl/rp_denorm.sv
// Tiny-path alignment: sticky right shift into the subnormal range, or the
// lift into the smallest normal when rounding at EMIN-1 carries out.
module rp_denorm #(
   parameter int SIG_W = 27,
   parameter int IW    = 12,
   parameter int EMIN  = -126
) (
   input  logic signed [IW-1:0] exp_in,
   input  logic [SIG_W-1:0]     sig_in,
   input  logic [SIG_W:0]       pre_sum,
   output logic [SIG_W-1:0]     sig_out,
   output logic signed [IW-1:0] exp_out,
   output logic                 is_tiny,
   output logic                 lift
);
   localparam int SHW = $clog2(SIG_W + 2);
   localparam logic signed [IW-1:0] EMIN_S  = IW'(EMIN);
   localparam logic signed [IW-1:0] EMIN_M1 = IW'(EMIN - 1);
   localparam logic signed [IW-1:0] AMT_CAP = IW'(SIG_W + 1);

   logic signed [IW-1:0] amt_full;
   logic [SHW-1:0]       amt;
   logic [SIG_W-1:0]     mask, shifted;
   logic                 sticky;
   logic                 unused_bit;

   assign is_tiny  = exp_in < EMIN_S;
   assign lift     = is_tiny && (exp_in == EMIN_M1) && pre_sum[SIG_W];
   assign amt_full = EMIN_S - exp_in;
   assign amt      = !is_tiny ? '0 :
                     (amt_full > AMT_CAP) ? AMT_CAP[SHW-1:0] : amt_full[SHW-1:0];
   assign mask     = ~({SIG_W{1'b1}} << amt);
   assign shifted  = sig_in >> amt;
   assign sticky   = |(sig_in & mask);
   assign unused_bit = pre_sum[0];

   always_comb begin
      if (!is_tiny)  sig_out = sig_in;
      else if (lift) sig_out = pre_sum[SIG_W:1] & ~{{(SIG_W-3){1'b0}}, 3'b111};
      else           sig_out = {shifted[SIG_W-1:1], shifted[0] | sticky};
   end

   assign exp_out = is_tiny ? EMIN_S : exp_in;

   // R6: a shifted tiny value never keeps its hidden bit
   always_comb begin
      if (is_tiny && !lift) assert (!sig_out[SIG_W-1]) else $error("a_r6_hidden_cleared");
   end
endmodule

// File: rtl/rp_pack.sv
// Final selection: flush results, overflow saturation, subnormal or normal pack.
module rp_pack #(
   parameter int FRAC_W = 23,
   parameter int EXP_W  = 8,
   parameter int IW     = 12
) (
   input  logic                 sign,
   input  logic [1:0]           mode,
   input  logic signed [IW-1:0] exp_r,
   input  logic [FRAC_W:0]      mant,
   input  logic                 inexact_in,
   input  logic                 uf_in,
   input  logic                 flush_hit,
   input  logic                 trap_en,
   output logic [EXP_W+FRAC_W:0] word,
   output logic                 inexact,
   output logic                 underflow,
   output logic                 overflow
);
   import rp_pkg::*;

   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic signed [IW-1:0] EMAX_S = IW'(BIAS);
   localparam logic signed [IW-1:0] BIAS_S = IW'(BIAS);

   logic [EXP_W+FRAC_W-1:0] mag_inf, mag_max, mag_min, mag_zero;
   logic signed [IW-1:0]    biased;
   logic                    unused_hi;

   assign mag_inf  = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};
   assign mag_max  = {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
   assign mag_min  = {{(EXP_W+FRAC_W-1){1'b0}}, 1'b1};
   assign mag_zero = '0;
   assign biased   = exp_r + BIAS_S;
   assign unused_hi = ^biased[IW-1:EXP_W];

   always_comb begin
      overflow  = 1'b0;
      inexact   = inexact_in;
      underflow = uf_in;
      word      = {sign, biased[EXP_W-1:0], mant[FRAC_W-1:0]};
      if (flush_hit) begin
         underflow = 1'b1;
         inexact   = 1'b1;
         case (rmode_e'(mode))
            RM_UP:   word = {sign, sign ? mag_zero : mag_min};
            RM_DOWN: word = {sign, sign ? mag_min : mag_zero};
            default: word = {sign, mag_zero};
         endcase
      end else if (exp_r > EMAX_S) begin
         overflow = 1'b1;
         inexact  = 1'b1;
         case (rmode_e'(mode))
            RM_NEAREST: word = {sign, mag_inf};
            RM_ZERO:    word = {sign, mag_max};
            RM_UP:      word = {sign, sign ? mag_max : mag_inf};
            default:    word = {sign, sign ? mag_inf : mag_max};
         endcase
      end else if (!mant[FRAC_W]) begin
         underflow = uf_in | trap_en;
         word      = {sign, {EXP_W{1'b0}}, mant[FRAC_W-1:0]};
      end
   end
endmodule

// File: rtl/rp_round_pack.sv
module rp_round_pack #(
   parameter int FRAC_W        = 23,
   parameter int EXP_W         = 8,
   parameter int EXP_IN_W      = 10,
   parameter bit FLUSH_SUPPORT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                in_sign,
   input  logic [EXP_IN_W-1:0] in_exp,
   input  logic [FRAC_W+3:0]   in_sig,
   input  logic [1:0]          rnd_mode,
   input  logic                flush_en,
   input  logic                uf_trap_en,
   output logic                out_valid,
   output logic [EXP_W+FRAC_W:0] out_word,
   output logic                out_inexact,
   output logic                out_underflow,
   output logic                out_overflow
);
   localparam int SIG_W  = FRAC_W + 4;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int EMIN   = 1 - BIAS;
   localparam int IW     = EXP_IN_W + 2;
   localparam int WORD_W = 1 + EXP_W + FRAC_W;

   if (EXP_IN_W < EXP_W + 2) begin : g_bad_exp_w
      $error("EXP_IN_W must be at least EXP_W+2");
   end
   if (FRAC_W < 4) begin : g_bad_frac_w
      $error("FRAC_W must be at least 4");
   end

   logic signed [IW-1:0] exp_ext, dn_exp, exp_r;
   logic [SIG_W:0]       pre_sum, main_sum;
   logic [SIG_W-1:0]     dn_sig;
   logic [FRAC_W:0]      mant;
   logic                 pre_nz, main_nz, is_tiny, lift, carry, flush_hit;
   logic [WORD_W-1:0]    word_c;
   logic                 inx_c, uf_c, ovf_c;
   logic                 unused_lo;

   assign exp_ext = IW'(signed'(in_exp));

   rp_round_inc #(.SIG_W(SIG_W)) u_pre (
      .sign(in_sign), .mode(rnd_mode), .sig(in_sig),
      .sum(pre_sum), .lost_nz(pre_nz));

   rp_denorm #(.SIG_W(SIG_W), .IW(IW), .EMIN(EMIN)) u_dn (
      .exp_in(exp_ext), .sig_in(in_sig), .pre_sum(pre_sum),
      .sig_out(dn_sig), .exp_out(dn_exp), .is_tiny(is_tiny), .lift(lift));

   rp_round_inc #(.SIG_W(SIG_W)) u_main (
      .sign(in_sign), .mode(rnd_mode), .sig(dn_sig),
      .sum(main_sum), .lost_nz(main_nz));

   assign carry = main_sum[SIG_W];
   assign mant  = carry ? main_sum[SIG_W:4] : main_sum[SIG_W-1:3];
   assign exp_r = dn_exp + IW'(carry);
   assign unused_lo = ^{main_sum[2:0], pre_nz};

   if (FLUSH_SUPPORT) begin : g_flush
      assign flush_hit = flush_en & is_tiny;
   end else begin : g_no_flush
      assign flush_hit = 1'b0 & flush_en;
   end

   rp_pack #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .IW(IW)) u_pack (
      .sign(in_sign), .mode(rnd_mode), .exp_r(exp_r), .mant(mant),
      .inexact_in(main_nz | lift),
      .uf_in(main_nz & ~dn_sig[SIG_W-1]),
      .flush_hit(flush_hit), .trap_en(uf_trap_en),
      .word(word_c), .inexact(inx_c), .underflow(uf_c), .overflow(ovf_c));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_word      <= '0;
         out_inexact   <= 1'b0;
         out_underflow <= 1'b0;
         out_overflow  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word      <= word_c;
            out_inexact   <= inx_c;
            out_underflow <= uf_c;
            out_overflow  <= ovf_c;
         end
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r11_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_word[WORD_W-1] == $past(in_sign));
   a_r9_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_overflow |-> out_inexact);
   a_r9_ovf_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_overflow |->
         (out_word[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}}) ||
         (out_word[WORD_W-2:0] == {{(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}}));
   a_r9_inf_needs_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (out_word[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}}) |-> out_overflow);
   a_r10_exact_uf_tiny: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_underflow && !out_inexact |->
         out_word[WORD_W-2 -: EXP_W] == {EXP_W{1'b0}});
endmodule

// File: tb/tb_rp_round_pack.sv
module tb_rp_round_pack;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sign = 1'b0;
   logic [9:0]  in_exp = '0;
   logic [26:0] in_sig = 27'h4000000;
   logic [1:0]  rnd_mode = '0;
   logic        flush_en = 1'b0, uf_trap_en = 1'b0;
   logic        out_valid;
   logic [31:0] out_word;
   logic        out_inexact, out_underflow, out_overflow;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rp_round_pack dut (.*);

   function automatic longint rnd(bit s, longint m, bit [1:0] md);
      if ((m & 7) == 0) return m;
      case (md)
         2'd0: return m + 3 + ((m >> 3) & 1);
         2'd2: return s ? m : m + 8;
         2'd3: return s ? m + 8 : m;
         default: return m;
      endcase
   endfunction

   // returns {word, inexact, underflow, overflow}
   function automatic logic [34:0] model(bit s, int e, logic [26:0] m0,
                                         bit [1:0] md, bit fl, bit tr);
      longint m = longint'(m0);
      int ex = e;
      bit inx = 0, uf = 0;
      logic [31:0] w;
      if (ex < -126) begin
         if (fl) begin
            case (md)
               2'd2: w = s ? 32'h80000000 : 32'h00000001;
               2'd3: w = s ? 32'h80000001 : 32'h00000000;
               default: w = {s, 31'h0};
            endcase
            return {w, 1'b1, 1'b1, 1'b0};
         end else if (ex == -127 && ((rnd(s, m, md) >> 27) != 0)) begin
            inx = 1;
            m = (rnd(s, m, md) >> 1) & ~longint'(7);
            ex = -126;
         end else begin
            int sh = -126 - ex;
            longint lost;
            if (sh > 40) sh = 40;
            lost = m & ((longint'(1) << sh) - 1);
            m = m >> sh;
            if (lost != 0) m = m | 1;
            ex = -126;
         end
      end
      if ((m & 7) != 0) begin
         inx = 1;
         if (((m >> 26) & 1) == 0) uf = 1;
         m = rnd(s, m, md);
         if ((m >> 27) != 0) begin m = m >> 1; ex++; end
      end
      m = m >> 3;
      if (ex > 127) begin
         case (md)
            2'd0: w = {s, 31'h7F800000};
            2'd1: w = {s, 31'h7F7FFFFF};
            2'd2: w = s ? 32'hFF7FFFFF : 32'h7F800000;
            default: w = s ? 32'hFF800000 : 32'h7F7FFFFF;
         endcase
         return {w, 1'b1, uf, 1'b1};
      end
      if (((m >> 23) & 1) == 0) begin
         if (tr) uf = 1;
         w = {s, 8'h00, m[22:0]};
      end else begin
         w = {s, 8'(ex + 127), m[22:0]};
      end
      return {w, inx, uf, 1'b0};
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic apply(string tag, bit s, int e, logic [26:0] m,
                        bit [1:0] md, bit fl, bit tr);
      logic [34:0] ex;
      @(negedge clk);
      in_valid = 1'b1; in_sign = s; in_exp = 10'(e); in_sig = m;
      rnd_mode = md; flush_en = fl; uf_trap_en = tr;
      ex = model(s, e, m, md, fl, tr);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk(tag, "valid (R1)", 64'(out_valid), 64'd1);
      chk(tag, "word", 64'(out_word), 64'(ex[34:3]));
      chk(tag, "flags i/u/o", 64'({out_inexact, out_underflow, out_overflow}),
          64'(ex[2:0]));
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", "reset valid", 64'(out_valid), 64'd0);
      chk("R1", "reset word", 64'(out_word), 64'd0);
      chk("R1", "reset flags", 64'({out_inexact, out_underflow, out_overflow}), 64'd0);

      apply("R5", 0, 0, 27'h4000000, 2'd0, 0, 0);
      chk("R5", "one", 64'(out_word), 64'h3F800000);
      apply("R11", 1, 5, 27'h4123450, 2'd1, 0, 0);
      chk("R11", "sign bit", 64'(out_word[31]), 64'd1);
      // R1: idle cycle keeps word, drops valid
      @(negedge clk);
      chk("R1", "idle valid", 64'(out_valid), 64'd0);
      chk("R1", "word held", 64'(out_word[31]), 64'd1);
      // R2 ties and modes
      apply("R2", 0, 0, 27'h4000004, 2'd0, 0, 0);
      chk("R2", "tie to even down", 64'(out_word), 64'h3F800000);
      apply("R2", 0, 0, 27'h400000C, 2'd0, 0, 0);
      chk("R2", "tie to even up", 64'(out_word), 64'h3F800002);
      for (int md = 0; md < 4; md++)
         for (int s = 0; s < 2; s++) apply("R2", s[0], 3, 27'h4000001, 2'(md), 0, 0);
      // R3 carry
      apply("R3", 0, 0, 27'h7FFFFFF, 2'd0, 0, 0);
      chk("R3", "carry renorm", 64'(out_word), 64'h40000000);
      // R7 not-tiny lift
      apply("R7", 0, -127, 27'h7FFFFFF, 2'd0, 0, 0);
      chk("R7", "smallest normal", 64'(out_word), 64'h00800000);
      chk("R7", "no underflow", 64'(out_underflow), 64'd0);
      // R6 / R10 exact subnormal
      apply("R10", 0, -127, 27'h4000000, 2'd0, 0, 0);
      chk("R10", "no uf without trap", 64'(out_underflow), 64'd0);
      apply("R10", 0, -127, 27'h4000000, 2'd0, 0, 1);
      chk("R10", "uf with trap", 64'(out_underflow), 64'd1);
      apply("R6", 0, -130, 27'h4000001, 2'd1, 0, 0);
      apply("R6", 0, -500, 27'h4000000, 2'd2, 0, 0);
      chk("R6", "sticky up to min", 64'(out_word), 64'h00000001);
      apply("R4", 1, -149, 27'h4000000, 2'd0, 0, 0);
      // R8 flush, R9 overflow for all modes and signs
      for (int md = 0; md < 4; md++)
         for (int s = 0; s < 2; s++) begin
            apply("R8", s[0], -140, 27'h4ABCDEF, 2'(md), 1, 0);
            apply("R9", s[0], 128, 27'h4000000, 2'(md), 0, 0);
            apply("R9", s[0], 127, 27'h7FFFFFF, 2'(md), 0, 0);
         end
      // constrained random
      for (int i = 0; i < 3000; i++) begin
         int e;
         logic [26:0] m;
         int pick = int'($urandom_range(0, 9));
         if (pick < 3)      e = int'($urandom_range(0, 8)) - 131;
         else if (pick < 5) e = int'($urandom_range(0, 6)) + 124;
         else if (pick < 6) e = int'($urandom_range(0, 1023)) - 512;
         else               e = int'($urandom_range(0, 300)) - 160;
         m = {1'b1, 26'($urandom)};
         if ($urandom_range(0, 3) == 0) m = 27'h7FFFFFF - 27'($urandom_range(0, 20));
         apply("R4", 1'($urandom), e, m, 2'($urandom), 1'($urandom_range(0, 3) == 0),
               1'($urandom));
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule